// File: doc/BRIEF.md
# Cluster Power Sequencer With Idle Gate

This block runs the shared power steps of one cluster of three cores. A one-cycle up request brings the cluster logic out of reset. This covers the interconnect-inactive handshake, the cluster power gate and the release of the debug, trace, L2 and SoC-debug resets. The per-core resets and per-core power-on resets stay asserted, because bringing up each core is a separate job.

A one-cycle down request takes the cluster down. It raises the interconnect-inactive handshake and waits for the L2 to report wait-for-interrupt, with a timeout. It then asserts the resets group by group, sets every power gate, and asks each core's power switch to open, one core at a time. In deferred mode the down request first waits for the whole cluster to be idle. It samples the idle condition when the request arrives and then once per retry period.

All waits are counted in clock cycles and set by parameters: a short settle, a long settle, the L2 timeout and the retry period. Control and status pins are plain levels or pulses. There is no streaming data path, so no valid/ready handshake is used.

Top module: `clus_pwr_seq`

## Requirements
- R1: After reset, every reset output is asserted and the power-on resets are asserted. All core gates and the cluster gate are set. The interconnect-inactive and L2 reset-hold outputs are high. Switch-off requests, busy, done and err are low. The reset vector is active low, with the core resets in bits 10:8, L2 in bit 7, debug in 6:4, trace in 3:1 and SoC-debug in bit 0.
- R2: When an up request is accepted in cycle E, the following outputs change:
  - core resets are asserted at E;
  - power-on resets are asserted at E+SHORT;
  - the L2, debug, trace and SoC-debug resets are asserted at E+2·SHORT;
  - at E+3·SHORT, L2 reset-hold goes low, interconnect-inactive goes high and the cluster gate clears;
  - at E+3·SHORT+LONG, interconnect-inactive goes low and the L2, debug, trace and SoC-debug resets release, while the core and power-on resets stay asserted.
- R3: When a down request is accepted in cycle E, interconnect-inactive rises at E. L2 wait-for-interrupt is first seen in cycle P-1, where P is at least E+1. From there:
  - core resets are asserted at P;
  - power-on resets are asserted at P+SHORT;
  - all remaining resets are asserted at P+2·SHORT;
  - the cluster gate and all core gates are set at P+3·SHORT.
- R4: Switch-off requests begin LONG cycles after the gates are set. The request vector is one-hot, starting with core 0. Each request holds until the acknowledge is sampled high, and the next core's request appears in the following cycle. After the last core is acknowledged, the request vector clears.
- R5: If L2 wait-for-interrupt is not seen within DRAIN_TO cycles of E, the sequence aborts at E+DRAIN_TO. At that point err rises, busy falls, interconnect-inactive falls and no other output changes. err clears when the next request is accepted.
- R6: In deferred mode, the cluster counts as idle only when all three core wait-for-interrupt bits and the L2 wait-for-interrupt bit are high. The condition is sampled at E and at every RETRY cycles after E. The drain step begins at the first sample that sees the cluster idle, and until then no output other than busy changes.
- R7: Up or down requests that arrive while busy is high have no effect.
- R8: When up and down requests arrive in the same idle cycle, the up request is taken.
- R9: busy is high from the accepting cycle until the sequence ends. At the end of a complete sequence, done pulses for one cycle in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Power-up request strobe |
| down_req | input | 1 | Power-down request strobe |
| defer_en | input | 1 | Down request waits for the cluster to be idle |
| core_wfi | input | 3 | Per-core wait-for-interrupt status |
| l2_wfi | input | 1 | L2 wait-for-interrupt status |
| sw_off_ack | input | 1 | Acknowledge of the current switch-off request |
| rst_vec_n | output | 11 | Active-low reset vector (core, L2, debug, trace, SoC-debug) |
| core_por_n | output | 3 | Active-low per-core power-on resets |
| core_gate | output | 3 | Per-core power-off gating |
| clus_gate | output | 1 | Cluster power-off gating |
| l2_rst_hold | output | 1 | L2 reset-disable level |
| ic_inactive | output | 1 | Interconnect-inactive handshake |
| sw_off_req | output | 3 | One-hot per-core power switch-off request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a complete sequence |
| err | output | 1 | L2 drain timed out; held until the next accepted request |

## Verification
Power-up is run three ways: from the reset state, from a fully powered-down cluster, and after an aborted drain. Each starting state hides a different subset of the steps, so the exact cycle of every visible change shows whether the step timer is shared correctly across steps. Power-down is run in three forms:
- with the L2 status arriving late and acknowledges given as isolated pulses and as a held level, which separates a per-acknowledge walk from one that skips or stalls;
- with the L2 status never arriving, which exercises the abort;
- in deferred mode with the idle condition met just after a failed check, which distinguishes a periodic check from a continuous one.

Requests made mid-sequence, and up and down requests made in the same cycle, show whether the block ignores requests while busy and whether up takes priority.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U_CORE,
    ST_U_POR,
    ST_U_CLR,
    ST_U_OPEN,
    ST_U_REL,
    ST_D_HOLD,
    ST_D_DRAIN,
    ST_D_CORE,
    ST_D_POR,
    ST_D_CLR,
    ST_D_GATE,
    ST_D_SW
  } cps_state_e;

  function automatic int cps_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cps_swoff.sv
module cps_swoff #(
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  output logic [NC-1:0] req,
  output logic          fin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                req <= '0;
    else if (start)            req <= NC'(1);
    else if (ack && (|req))    req <= req << 1;
  end

  // last core acknowledged: the walk ends on this edge
  assign fin = ack & req[NC-1];

endmodule

// File: rtl/clus_pwr_seq.sv
module clus_pwr_seq
  import cps_pkg::*;
#(
  parameter int NC        = 3,
  parameter int SHORT_CYC = 500,
  parameter int LONG_CYC  = 1000,
  parameter int DRAIN_TO  = 5000,
  parameter int RETRY_CYC = 500000,
  localparam int RW       = 3*NC + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          down_req,
  input  logic          defer_en,
  input  logic [NC-1:0] core_wfi,
  input  logic          l2_wfi,
  input  logic          sw_off_ack,
  output logic [RW-1:0] rst_vec_n,
  output logic [NC-1:0] core_por_n,
  output logic [NC-1:0] core_gate,
  output logic          clus_gate,
  output logic          l2_rst_hold,
  output logic          ic_inactive,
  output logic [NC-1:0] sw_off_req,
  output logic          busy,
  output logic          done,
  output logic          err
);

  localparam int MAXC = cps_max(cps_max(SHORT_CYC, LONG_CYC), cps_max(DRAIN_TO, RETRY_CYC));
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] T_SHORT = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] T_LONG  = TW'(LONG_CYC - 1);
  localparam logic [TW-1:0] T_DRAIN = TW'(DRAIN_TO - 1);
  localparam logic [TW-1:0] T_RETRY = TW'(RETRY_CYC - 1);

  cps_state_e    state_q, nxt;
  logic          go, tmr_exp, sw_start, sw_fin, seq_end, abort;
  logic [TW-1:0] tval;
  logic          clus_idle;

  logic [NC-1:0] core_n_q, por_n_q, dbg_n_q, trc_n_q, core_gate_q;
  logic          l2_n_q, soc_n_q, clus_gate_q, l2_hold_q, ic_q, done_q, err_q;

  assign clus_idle = (&core_wfi) & l2_wfi;

  cps_timer #(.TW(TW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .load_val (tval),
    .expired  (tmr_exp)
  );

  cps_swoff #(.NC(NC)) sw_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sw_start),
    .ack   (sw_off_ack),
    .req   (sw_off_req),
    .fin   (sw_fin)
  );

  // step selection: every transition reloads the shared timer
  always_comb begin
    go       = 1'b0;
    nxt      = state_q;
    tval     = '0;
    sw_start = 1'b0;
    seq_end  = 1'b0;
    abort    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (up_req) begin
          go = 1'b1; nxt = ST_U_CORE; tval = T_SHORT;
        end else if (down_req) begin
          go = 1'b1;
          if (defer_en && !clus_idle) begin
            nxt = ST_D_HOLD; tval = T_RETRY;
          end else begin
            nxt = ST_D_DRAIN; tval = T_DRAIN;
          end
        end
      end
      ST_U_CORE:  if (tmr_exp) begin go = 1'b1; nxt = ST_U_POR;  tval = T_SHORT; end
      ST_U_POR:   if (tmr_exp) begin go = 1'b1; nxt = ST_U_CLR;  tval = T_SHORT; end
      ST_U_CLR:   if (tmr_exp) begin go = 1'b1; nxt = ST_U_OPEN; tval = T_LONG;  end
      ST_U_OPEN:  if (tmr_exp) begin go = 1'b1; nxt = ST_U_REL;  tval = T_LONG;  end
      ST_U_REL:   if (tmr_exp) begin go = 1'b1; nxt = ST_IDLE;   seq_end = 1'b1; end
      ST_D_HOLD: begin
        if (tmr_exp) begin
          go = 1'b1;
          if (clus_idle) begin nxt = ST_D_DRAIN; tval = T_DRAIN; end
          else           begin nxt = ST_D_HOLD;  tval = T_RETRY; end
        end
      end
      ST_D_DRAIN: begin
        if (l2_wfi) begin
          go = 1'b1; nxt = ST_D_CORE; tval = T_SHORT;
        end else if (tmr_exp) begin
          go = 1'b1; nxt = ST_IDLE; abort = 1'b1;
        end
      end
      ST_D_CORE:  if (tmr_exp) begin go = 1'b1; nxt = ST_D_POR;  tval = T_SHORT; end
      ST_D_POR:   if (tmr_exp) begin go = 1'b1; nxt = ST_D_CLR;  tval = T_SHORT; end
      ST_D_CLR:   if (tmr_exp) begin go = 1'b1; nxt = ST_D_GATE; tval = T_LONG;  end
      ST_D_GATE:  if (tmr_exp) begin go = 1'b1; nxt = ST_D_SW;   sw_start = 1'b1; end
      ST_D_SW:    if (sw_fin)  begin go = 1'b1; nxt = ST_IDLE;   seq_end = 1'b1; end
      default: begin
        go = 1'b1; nxt = ST_IDLE;
      end
    endcase
  end

  // outputs change on entry to a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      core_n_q    <= '0;
      por_n_q     <= '0;
      dbg_n_q     <= '0;
      trc_n_q     <= '0;
      l2_n_q      <= 1'b0;
      soc_n_q     <= 1'b0;
      core_gate_q <= '1;
      clus_gate_q <= 1'b1;
      l2_hold_q   <= 1'b1;
      ic_q        <= 1'b1;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        state_q <= nxt;
        unique case (nxt)
          ST_U_CORE: begin core_n_q <= '0; err_q <= 1'b0; end
          ST_U_POR:  por_n_q <= '0;
          ST_U_CLR: begin
            l2_n_q <= 1'b0; soc_n_q <= 1'b0; dbg_n_q <= '0; trc_n_q <= '0;
          end
          ST_U_OPEN: begin l2_hold_q <= 1'b0; ic_q <= 1'b1; clus_gate_q <= 1'b0; end
          ST_U_REL: begin
            ic_q <= 1'b0;
            l2_n_q <= 1'b1; soc_n_q <= 1'b1; dbg_n_q <= '1; trc_n_q <= '1;
          end
          ST_D_HOLD:  err_q <= 1'b0;
          ST_D_DRAIN: begin ic_q <= 1'b1; err_q <= 1'b0; end
          ST_D_CORE:  core_n_q <= '0;
          ST_D_POR:   por_n_q <= '0;
          ST_D_CLR: begin
            l2_n_q <= 1'b0; soc_n_q <= 1'b0; dbg_n_q <= '0; trc_n_q <= '0;
          end
          ST_D_GATE: begin clus_gate_q <= 1'b1; core_gate_q <= '1; end
          ST_IDLE: begin
            if (seq_end) done_q <= 1'b1;
            if (abort) begin err_q <= 1'b1; ic_q <= 1'b0; end
          end
          default: ;
        endcase
      end
    end
  end

  assign rst_vec_n   = {core_n_q, l2_n_q, dbg_n_q, trc_n_q, soc_n_q};
  assign core_por_n  = por_n_q;
  assign core_gate   = core_gate_q;
  assign clus_gate   = clus_gate_q;
  assign l2_rst_hold = l2_hold_q;
  assign ic_inactive = ic_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int NC = 3,
  localparam int RW = 3*NC + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_off_ack,
  input logic [RW-1:0] rst_vec_n,
  input logic [NC-1:0] core_gate,
  input logic          clus_gate,
  input logic          ic_inactive,
  input logic [NC-1:0] sw_off_req,
  input logic          busy,
  input logic          done,
  input logic          err
);

  a_r4_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_off_req));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sw_off_req) && !sw_off_ack) |=> $stable(sw_off_req));

  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_off_req) |-> (clus_gate && (&core_gate)));

  a_r3_gate_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clus_gate) |-> (rst_vec_n == '0));

  a_r2_open_with_ic: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clus_gate) |-> ic_inactive);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !ic_inactive));

endmodule

bind clus_pwr_seq cps_chk #(.NC(NC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_off_ack  (sw_off_ack),
  .rst_vec_n   (rst_vec_n),
  .core_gate   (core_gate),
  .clus_gate   (clus_gate),
  .ic_inactive (ic_inactive),
  .sw_off_req  (sw_off_req),
  .busy        (busy),
  .done        (done),
  .err         (err)
);

// File: tb/clus_pwr_seq_tb.sv
module clus_pwr_seq_tb_top;

  localparam int NC = 3;
  localparam int S  = 4;
  localparam int L  = 7;
  localparam int TO = 20;
  localparam int R  = 10;
  localparam int RW = 3*NC + 2;
  localparam int BW = RW + 4*NC + 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          up_req = 1'b0, down_req = 1'b0, defer_en = 1'b0;
  logic [NC-1:0] core_wfi = '0;
  logic          l2_wfi = 1'b0, sw_off_ack = 1'b0;
  logic [RW-1:0] rst_vec_n;
  logic [NC-1:0] core_por_n, core_gate, sw_off_req;
  logic          clus_gate, l2_rst_hold, ic_inactive, busy, done, err;

  clus_pwr_seq #(.NC(NC), .SHORT_CYC(S), .LONG_CYC(L), .DRAIN_TO(TO), .RETRY_CYC(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req), .defer_en(defer_en),
    .core_wfi(core_wfi), .l2_wfi(l2_wfi), .sw_off_ack(sw_off_ack),
    .rst_vec_n(rst_vec_n), .core_por_n(core_por_n), .core_gate(core_gate),
    .clus_gate(clus_gate), .l2_rst_hold(l2_rst_hold), .ic_inactive(ic_inactive),
    .sw_off_req(sw_off_req), .busy(busy), .done(done), .err(err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0;
  int checks = 0;

  // reference model of the outputs
  logic [RW-1:0] m_rst;
  logic [NC-1:0] m_por, m_cg, m_sw;
  logic          m_clg, m_ic, m_l2h, m_busy, m_done, m_err;

  typedef struct {
    int            at;
    logic [BW-1:0] val;
    string         tag;
  } exp_t;

  exp_t          q[$];
  logic [BW-1:0] last_v, prev_v, mon_cur;
  exp_t          mon_e;
  bit            mon_on = 0;

  function automatic logic [BW-1:0] m_pack();
    return {m_rst, m_por, m_cg, m_clg, m_ic, m_l2h, m_sw, m_busy, m_done, m_err};
  endfunction

  function automatic logic [BW-1:0] dut_pack();
    return {rst_vec_n, core_por_n, core_gate, clus_gate, ic_inactive, l2_rst_hold,
            sw_off_req, busy, done, err};
  endfunction

  // driver side: queue an expected output change
  task automatic push(int at, string tag);
    exp_t e;
    if (m_pack() !== last_v) begin
      e.at  = at;
      e.val = m_pack();
      e.tag = tag;
      q.push_back(e);
      last_v = e.val;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every output change must match the next expected item
  always @(negedge clk) begin
    if (mon_on) begin
      mon_cur = dut_pack();
      if (mon_cur !== prev_v) begin
        checks++;
        if (q.size() == 0) begin
          errs++;
          $display("FAIL R7: unexpected change at cycle %0d actual %h expected %h",
                   cyc, mon_cur, prev_v);
        end else begin
          mon_e = q.pop_front();
          if (mon_e.at != cyc || mon_e.val !== mon_cur) begin
            errs++;
            $display("FAIL %s: actual cycle %0d value %h expected cycle %0d value %h",
                     mon_e.tag, cyc, mon_cur, mon_e.at, mon_e.val);
          end
        end
        prev_v = mon_cur;
      end
    end
  end

  // power-up; both=1 also raises down_req in the same cycle (R8)
  task automatic go_up(bit both);
    int    e;
    string t0;
    e  = cyc + 1;
    t0 = both ? "R8" : "R2";
    m_busy = 1'b1; m_err = 1'b0; m_done = 1'b0; m_rst[RW-1 -: NC] = '0;
    push(e, t0);
    m_por = '0;                       push(e + S, "R2");
    m_rst[RW-NC-1:0] = '0;            push(e + 2*S, "R2");
    m_l2h = 1'b0; m_ic = 1'b1; m_clg = 1'b0;
    push(e + 3*S, t0);
    m_ic = 1'b0; m_rst[RW-NC-1:0] = '1;
    push(e + 3*S + L, "R2");
    m_busy = 1'b0; m_done = 1'b1;     push(e + 3*S + 2*L, "R9");
    m_done = 1'b0;                    push(e + 3*S + 2*L + 1, "R9");
    up_req = 1'b1; down_req = both;
    @(negedge clk); up_req = 1'b0; down_req = 1'b0;
    wait_cyc(e + 2);                  // R7: down while busy
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
    wait_cyc(e + 3*S + 1);            // R7: up while busy
    up_req = 1'b1; @(negedge clk); up_req = 1'b0;
    wait_cyc(e + 3*S + 2*L + 4);
  endtask

  initial begin
    int e, p, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    m_rst = '0; m_por = '0; m_cg = '1; m_clg = 1'b1; m_ic = 1'b1; m_l2h = 1'b1;
    m_sw = '0; m_busy = 1'b0; m_done = 1'b0; m_err = 1'b0;
    last_v = m_pack();
    chk(dut_pack() === m_pack(), "R1", 32'(dut_pack()), 32'(m_pack()));
    prev_v = dut_pack();
    mon_on = 1;
    repeat (2) @(negedge clk);

    // power-up from reset, with requests while busy
    go_up(1'b0);

    // R3/R4 immediate power-down, L2 late, acks as pulse and as held level
    e = cyc + 1;
    m_busy = 1'b1; m_ic = 1'b1; push(e, "R3");
    p = e + 6;
    m_rst[RW-1 -: NC] = '0;  push(p, "R3");
    m_por = '0;              push(p + S, "R3");
    m_rst = '0;              push(p + 2*S, "R3");
    m_cg = '1; m_clg = 1'b1; push(p + 3*S, "R3");
    x = p + 3*S + L;
    m_sw = 3'b001;           push(x, "R4");
    m_sw = 3'b010;           push(x + 4, "R4");
    m_sw = 3'b100;           push(x + 7, "R4");
    m_sw = '0; m_busy = 1'b0; m_done = 1'b1; push(x + 8, "R4");
    m_done = 1'b0;           push(x + 9, "R9");
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
    wait_cyc(e + 5); l2_wfi = 1'b1;
    wait_cyc(x + 3); sw_off_ack = 1'b1; @(negedge clk); sw_off_ack = 1'b0;
    wait_cyc(x + 6); sw_off_ack = 1'b1; @(negedge clk); @(negedge clk); sw_off_ack = 1'b0;
    wait_cyc(x + 12);
    l2_wfi = 1'b0;

    // power-up from a powered-down cluster, then R5 drain timeout
    go_up(1'b0);
    e = cyc + 1;
    m_busy = 1'b1; m_ic = 1'b1; push(e, "R5");
    m_busy = 1'b0; m_ic = 1'b0; m_err = 1'b1; push(e + TO, "R5");
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
    wait_cyc(e + TO + 2);
    chk(err === 1'b1 && busy === 1'b0, "R5", {30'd0, err, busy}, 32'd2);
    chk(rst_vec_n === 11'h0FF, "R5", 32'(rst_vec_n), 32'h0FF);
    go_up(1'b0);                       // err clears on accepted request (R5)

    // R6 deferred down: not idle at first two checks, idle before the third
    defer_en = 1'b1; core_wfi = 3'b011; l2_wfi = 1'b1; sw_off_ack = 1'b1;
    @(negedge clk);
    e = cyc + 1;
    m_busy = 1'b1; push(e, "R6");
    m_ic = 1'b1;   push(e + 2*R, "R6");
    p = e + 2*R + 1;
    m_rst = '0;              push(p + 2*S, "R6");
    m_cg = '1; m_clg = 1'b1; push(p + 3*S, "R6");
    x = p + 3*S + L;
    m_sw = 3'b001;           push(x, "R4");
    m_sw = 3'b010;           push(x + 1, "R4");
    m_sw = 3'b100;           push(x + 2, "R4");
    m_sw = '0; m_busy = 1'b0; m_done = 1'b1; push(x + 3, "R4");
    m_done = 1'b0;           push(x + 4, "R9");
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
    wait_cyc(e + R + 3); core_wfi = 3'b111;
    wait_cyc(x + 6);
    sw_off_ack = 1'b0; defer_en = 1'b0; core_wfi = '0; l2_wfi = 1'b0;

    // R8 simultaneous up and down
    go_up(1'b1);

    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errs++;
      $display("FAIL %s: actual %0d changes missing expected 0 (first due cycle %0d)",
               q[0].tag, q.size(), q[0].at);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule